// File: doc/BRIEF.md
# Shared Polynomial Noise Source Bank

This block holds one set of three free-running pseudo-random shift registers, 17, 5 and 4 bits long. All three advance on every clock cycle of the fast system clock. The 17-bit register can be switched to run as a 9-bit register. Any number of audio channels (four by default) read these generators. Each channel samples them only in a cycle in which its own frequency divider pulses. So one shared set of generators looks, from each channel, like a private set that runs at that channel's divider rate, and each channel's noise is low-passed by its divider.

Each channel has a 3-bit selector. The selector picks one of three behaviours: a plain square-wave toggle, a toggle gated by the 5-bit generator, or a noise bit sampled from the long (17/9-bit) generator or the 4-bit generator. The 5-bit generator can gate the sampled noise bit, or a field of the selector can bypass that gate. Dividers, filters and volume stages sit outside this block. The block takes divider pulses in and gives one tone or noise bit out per channel. Each output is a register that changes only on the clock edge at which its pulse is high.

Top module: `noise_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every `ch_out` bit becomes 0 and every generator register is loaded with all ones.
- R2: The 4-bit generator shifts left every cycle. Its new bit 0 is bit3 XOR bit2, and its output is bit 3.
- R3: The 5-bit generator shifts left every cycle. Its new bit 0 is bit4 XOR bit2, and its output is bit 4.
- R4: With `short_poly` low, the 17-bit generator shifts left every cycle. Its new bit 0 is bit16 XOR bit13, and its output is bit 16.
- R5: With `short_poly` high, the 17-bit generator still shifts left each cycle, but its new bit 0 is bit8 XOR bit4 and its output is bit 8. A change of `short_poly` takes effect at the next edge and does not reload the register.
- R6: When the bits that feed back (all 17, or the low 9 in short mode) are all zero, the new bit 0 is forced to 1. No generator is ever all zero after reset.
- R7: A channel output changes only at a clock edge where that channel's `ch_pulse` bit is high.
- R8: Selector value `?11` (bit1=1, bit0=1) makes the channel toggle on every pulse, which gives a pure tone.
- R9: With selector bit0 = 0, a pulse arriving while the 5-bit generator output is 0 leaves the channel output unchanged.
- R10: With selector bit1 = 0, a pulse whose gate is open (bit0 = 1 or the 5-bit output = 1) loads the channel output with the generator bit present before that edge. Selector bit2 = 0 picks the long generator and bit2 = 1 picks the 4-bit generator.
- R11: Selector value `?10` makes the channel toggle on a pulse only when the 5-bit generator output is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock; generators step on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| short_poly | input | 1 | High: long generator runs as a 9-bit register |
| ch_pulse | input | NUM_CH | One divider pulse per channel, one cycle wide |
| ch_sel | input | 3*NUM_CH | Per-channel selector; channel i uses bits [3i+2:3i] |
| ch_out | output | NUM_CH | Registered tone/noise bit per channel |

## Verification
The checker assumes that reset is held for at least one edge before any check matters. It also assumes that `ch_pulse`, `ch_sel` and `short_poly` are steady around each rising edge, so each edge sees one clean sample of the selector and the gate. The bench changes all inputs only on falling edges. It holds a selector fixed for many cycles and then changes it at random, so each mode runs across long stretches of generator state. It also switches `short_poly` at random times, which reaches the all-zero low-nine state that the lock-up guard must handle.

// File: rtl/noise_bank_pkg.sv
package noise_bank_pkg;
  localparam int LONG_W  = 17;
  localparam int LONG_T  = 14;
  localparam int SHORT_W = 9;
  localparam int SHORT_T = 5;
  localparam int MID_W   = 5;
  localparam int MID_T   = 3;
  localparam int TINY_W  = 4;
  localparam int TINY_T  = 3;
  localparam int SEL_W   = 3;

  typedef struct packed {
    logic src_tiny;  // 1: 4-bit source, 0: long source
    logic tone;      // 1: toggle instead of sampling noise
    logic open_gate; // 1: ignore the 5-bit gate
  } chsel_t;
endpackage

// File: rtl/poly_lfsr.sv
module poly_lfsr #(
  parameter int W    = 5,
  parameter int TAP  = 3,
  parameter int SW   = W,
  parameter int STAP = TAP
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         short_mode,
  output logic [W-1:0] state,
  output logic         out_bit
);
  logic fb_long, fb_short, fb;

  always_comb begin
    fb_long  = (state == '0) ? 1'b1 : (state[W-1] ^ state[TAP-1]);
    fb_short = (state[SW-1:0] == '0) ? 1'b1 : (state[SW-1] ^ state[STAP-1]);
    fb       = short_mode ? fb_short : fb_long;
    out_bit  = short_mode ? state[SW-1] : state[W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) state <= '1;
    else     state <= {state[W-2:0], fb};
  end
endmodule

// File: rtl/noise_channel.sv
module noise_channel
  import noise_bank_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   pulse,
  input  chsel_t sel,
  input  logic   src_long,
  input  logic   src_tiny,
  input  logic   src_mid,
  output logic   q
);
  logic gate, nxt;

  always_comb begin
    gate = sel.open_gate | src_mid;
    if (sel.tone) nxt = ~q;
    else          nxt = sel.src_tiny ? src_tiny : src_long;
  end

  always_ff @(posedge clk) begin
    if (rst)               q <= 1'b0;
    else if (pulse && gate) q <= nxt;
  end
endmodule

// File: rtl/noise_bank.sv
module noise_bank
  import noise_bank_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    short_poly,
  input  logic [NUM_CH-1:0]       ch_pulse,
  input  logic [SEL_W*NUM_CH-1:0] ch_sel,
  output logic [NUM_CH-1:0]       ch_out
);
  logic [LONG_W-1:0] st17;
  logic [MID_W-1:0]  st5;
  logic [TINY_W-1:0] st4;
  logic o17, o5, o4;

  poly_lfsr #(.W(LONG_W), .TAP(LONG_T), .SW(SHORT_W), .STAP(SHORT_T)) u_long (
    .clk(clk), .rst(rst), .short_mode(short_poly), .state(st17), .out_bit(o17));

  poly_lfsr #(.W(MID_W), .TAP(MID_T)) u_mid (
    .clk(clk), .rst(rst), .short_mode(1'b0), .state(st5), .out_bit(o5));

  poly_lfsr #(.W(TINY_W), .TAP(TINY_T)) u_tiny (
    .clk(clk), .rst(rst), .short_mode(1'b0), .state(st4), .out_bit(o4));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    noise_channel u_ch (
      .clk(clk), .rst(rst), .pulse(ch_pulse[i]),
      .sel(chsel_t'(ch_sel[SEL_W*i +: SEL_W])),
      .src_long(o17), .src_tiny(o4), .src_mid(o5), .q(ch_out[i]));
  end
endmodule

// File: rtl/noise_bank_checker.sv
module noise_bank_checker #(
  parameter int NUM_CH = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                short_poly,
  input logic [NUM_CH-1:0]   ch_pulse,
  input logic [3*NUM_CH-1:0] ch_sel,
  input logic [NUM_CH-1:0]   ch_out,
  input logic [16:0]         g17,
  input logic [4:0]          g5,
  input logic [3:0]          g4
);
  AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (g17 != 17'd0) && (g5 != 5'd0) && (g4 != 4'd0)); // R6
  AST_SHORT_LOW_NONZERO: assert property (@(posedge clk) disable iff (rst)
    short_poly |=> (g17[8:0] != 9'd0)); // R6
  AST_TINY_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (g4 == {$past(g4[2:0]), $past(g4[3]) ^ $past(g4[2])})); // R2
  AST_MID_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (g5 == {$past(g5[3:0]), $past(g5[4]) ^ $past(g5[2])})); // R3
  AST_LONG_STEP: assert property (@(posedge clk) disable iff (rst)
    !short_poly |=> (g17 == {$past(g17[15:0]), $past(g17[16]) ^ $past(g17[13])})); // R4

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !ch_pulse[i] |=> $stable(ch_out[i])); // R7
    AST_TONE_FLIP: assert property (@(posedge clk) disable iff (rst)
      (ch_pulse[i] && ch_sel[3*i+1] && ch_sel[3*i]) |=> (ch_out[i] != $past(ch_out[i]))); // R8
    AST_GATE_SHUT: assert property (@(posedge clk) disable iff (rst)
      (ch_pulse[i] && !ch_sel[3*i] && !g5[4]) |=> $stable(ch_out[i])); // R9
  end
endmodule

bind noise_bank noise_bank_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .short_poly(short_poly), .ch_pulse(ch_pulse),
  .ch_sel(ch_sel), .ch_out(ch_out), .g17(st17), .g5(st5), .g4(st4));

// File: tb/noise_bank_test.sv
module noise_bank_test;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           short_poly = 1'b0;
  logic [NCH-1:0] ch_pulse = '0;
  logic [3*NCH-1:0] ch_sel = '0;
  logic [NCH-1:0] ch_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  noise_bank #(.NUM_CH(NCH)) uut (
    .clk(clk), .rst(rst), .short_poly(short_poly),
    .ch_pulse(ch_pulse), .ch_sel(ch_sel), .ch_out(ch_out));

  // Bench model of the generators and channels, built from the requirements
  logic [16:0] m17;
  logic [4:0]  m5;
  logic [3:0]  m4;
  logic [NCH-1:0] exp_out = '0;
  logic [NCH-1:0] last_pulse = '0;
  logic [3*NCH-1:0] last_sel = '0;
  logic last_short = 1'b0;

  function automatic string tag_of(logic p, logic [2:0] s, logic sh);
    if (!p)             return "R7";
    if (s[1] && s[0])   return "R8";
    if (s[1])           return "R11/R3";
    if (!s[0])          return "R9/R10/R3";
    if (s[2])           return "R10/R2";
    return sh ? "R10/R5/R6" : "R10/R4";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m17 = '1; m5 = '1; m4 = '1;   // R1 seeds
      exp_out = '0;
    end else begin
      logic f17, f5, f4, src;
      for (int c = 0; c < NCH; c++) begin
        logic [2:0] s;
        s = ch_sel[3*c +: 3];
        if (ch_pulse[c] && (s[0] || m5[4])) begin
          src = s[2] ? m4[3] : (short_poly ? m17[8] : m17[16]);
          exp_out[c] = s[1] ? ~exp_out[c] : src;
        end
      end
      // R2 4-bit, R3 5-bit, R4/R5 long with R6 guard
      f4 = (m4 == 0) ? 1'b1 : (m4[3] ^ m4[2]);
      f5 = (m5 == 0) ? 1'b1 : (m5[4] ^ m5[2]);
      if (short_poly) f17 = (m17[8:0] == 0) ? 1'b1 : (m17[8] ^ m17[4]);
      else            f17 = (m17 == 0) ? 1'b1 : (m17[16] ^ m17[13]);
      m4  = {m4[2:0], f4};
      m5  = {m5[3:0], f5};
      m17 = {m17[15:0], f17};
    end
    last_pulse = ch_pulse;
    last_sel   = ch_sel;
    last_short = short_poly;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int c = 0; c < NCH; c++) begin
        checks++;
        if (ch_out[c] !== exp_out[c]) begin
          fails++;
          $display("FAIL %s ch%0d t=%0t: got %b expected %b", tag_of(last_pulse[c],
                   last_sel[3*c +: 3], last_short), c, $time, ch_out[c], exp_out[c]);
        end
      end
    end
  end

  task automatic set_all(input logic [2:0] s);
    for (int c = 0; c < NCH; c++) ch_sel[3*c +: 3] = s;
  endtask

  task automatic run_directed(input logic [2:0] s, input logic sh, input int n);
    @(negedge clk);
    set_all(s);
    short_poly = sh;
    ch_pulse = '1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    checks++;                      // R1 reset state
    if (ch_out !== '0) begin
      fails++;
      $display("FAIL R1: got %b expected %b", ch_out, {NCH{1'b0}});
    end
    rst = 1'b0;
    run_directed(3'b011, 1'b0, 40);   // R8 tone
    run_directed(3'b001, 1'b0, 300);  // R4 long
    run_directed(3'b001, 1'b1, 300);  // R5 short
    run_directed(3'b101, 1'b0, 60);   // R2 tiny
    run_directed(3'b010, 1'b0, 80);   // R11 gated toggle
    run_directed(3'b000, 1'b1, 80);   // R9/R10 gated noise
    @(negedge clk);
    ch_pulse = '0;
    set_all(3'b011);
    repeat (20) @(negedge clk);       // R7 no pulses, no change
    for (int k = 0; k < 30000; k++) begin
      ch_pulse = NCH'($urandom);
      if (($urandom % 4) == 0) ch_pulse = '1;
      if (($urandom % 64) == 0) ch_sel[3*($urandom % NCH) +: 3] = 3'($urandom);
      if (($urandom % 200) == 0) short_poly = ~short_poly;
      @(negedge clk);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule